// File: doc/BRIEF.md
# Barrel Shift/Rotate Unit

This block moves a 16-bit data word left or right by a variable number of bit positions in a single combinational pass. The distance comes from a second 16-bit operand. Two control bits pick the operation. One bit sets the direction of travel. The other bit chooses between a logical move, which fills the vacated positions with zeros, and a rotate, which feeds the bits that leave one end back in at the other end. All four operations share one log-depth structure. It is a chain of conditional move stages of 1, 2, 4 and 8 positions, and each stage is enabled by one bit of the distance.

The unit has no clock and no state. A datapath uses it as one functional slot of an arithmetic/logic unit. The result is valid as soon as the inputs settle, and the caller registers it wherever its own pipeline needs it. Only the low four bits of the distance operand set the move. The upper twelve bits matter only for logical moves: any nonzero bit there gives a result of all zeros, because every bit would have been moved out of the word.

Top module: `barrel_shift_rotate`

## Requirements
- R1: When the move distance is zero, `shift_out` equals `operand_a` in all four modes. For rotates this means `operand_b[3:0] == 0`. For logical moves it means `operand_b == 0`.
- R2: With `dir_right = 0` and `mode_rotate = 0` and `operand_b[15:4] == 0`, `shift_out` equals `operand_a` moved left by `operand_b[3:0]`, with zeros in the low positions.
- R3: With `dir_right = 1` and `mode_rotate = 0` and `operand_b[15:4] == 0`, `shift_out` equals `operand_a` moved right by `operand_b[3:0]`, with zeros in the high positions.
- R4: With `dir_right = 0` and `mode_rotate = 1`, bit i of `shift_out` equals bit (i - n) mod 16 of `operand_a`, where n = `operand_b[3:0]`.
- R5: With `dir_right = 1` and `mode_rotate = 1`, bit i of `shift_out` equals bit (i + n) mod 16 of `operand_a`, where n = `operand_b[3:0]`.
- R6: With `mode_rotate = 0`, any nonzero bit in `operand_b[15:4]` makes `shift_out` all zeros, in both directions.
- R7: With `mode_rotate = 1`, `operand_b[15:4]` has no effect on `shift_out`. The result equals the one given for the same `operand_b[3:0]` with the upper bits cleared.
- R8: A rotate never changes the number of one bits: the population count of `shift_out` equals that of `operand_a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_a | input | 16 | Data word to be moved |
| operand_b | input | 16 | Move distance; bits [3:0] give the count, bits [15:4] force zero on logical moves |
| dir_right | input | 1 | 0 moves toward the MSB (left), 1 moves toward the LSB (right) |
| mode_rotate | input | 1 | 0 logical move with zero fill, 1 rotate with wrap-around |
| shift_out | output | 16 | Moved or rotated result |

## Verification
The block holds no state, so a wrong select or a wrong fill path shows at `shift_out` in the same evaluation in which the inputs are applied. There is no latency to wait out. A stage wired to the wrong distance, or a stage that ignores its enable bit, corrupts only those distances whose matching bit is set. For that reason every distance from 0 to 15 is applied in each mode, over several data patterns. A broken wrap path shows up as zeros where data bits should return, and the bit-count check on rotates catches it at once. A leak of the upper distance bits into rotates, or a missing zero-force on logical moves, is exposed by repeating the sweep with the upper bits set.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    // Data width of the unit; must be a power of two.
    parameter int DATA_W = 16;

    // Number of distance bits that steer the stages.
    localparam int CNT_W = $clog2(DATA_W);

    typedef logic [DATA_W-1:0] word_t;

    // Operation select shared by every stage.
    typedef struct packed {
        logic right;   // 1: toward LSB
        logic rotate;  // 1: wrap bits around instead of zero fill
    } move_ctrl_t;

endpackage

// File: rtl/bsr_stage.sv
// One conditional move stage: moves by a fixed distance DIST when take is set.
module bsr_stage #(
    parameter int WIDTH = 16,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0]  stage_in,
    input  logic              take,
    input  bsr_pkg::move_ctrl_t ctrl,
    output logic [WIDTH-1:0]  stage_out
);

    logic [DIST-1:0]  fill_low_d;   // enters at the LSB end on a left move
    logic [DIST-1:0]  fill_high_d;  // enters at the MSB end on a right move
    logic [WIDTH-1:0] left_d;
    logic [WIDTH-1:0] right_d;

    always_comb begin
        fill_low_d  = ctrl.rotate ? stage_in[WIDTH-1:WIDTH-DIST] : '0;
        fill_high_d = ctrl.rotate ? stage_in[DIST-1:0]           : '0;
        left_d      = {stage_in[WIDTH-1-DIST:0], fill_low_d};
        right_d     = {fill_high_d, stage_in[WIDTH-1:DIST]};
        if (!take) begin
            stage_out = stage_in;
        end else if (ctrl.right) begin
            stage_out = right_d;
        end else begin
            stage_out = left_d;
        end
    end

endmodule

// File: rtl/bsr_range_guard.sv
// Forces a zero result when a logical move runs past the word width.
module bsr_range_guard #(
    parameter int WIDTH = 16,
    parameter int HI_W  = 12
) (
    input  logic [WIDTH-1:0] staged,
    input  logic [HI_W-1:0]  dist_high,
    input  logic             rotate,
    output logic [WIDTH-1:0] guarded
);

    logic overrange_d;

    always_comb begin
        overrange_d = !rotate && (dist_high != '0);
        guarded     = overrange_d ? '0 : staged;
    end

endmodule

// File: rtl/barrel_shift_rotate.sv
module barrel_shift_rotate #(
    parameter int WIDTH = bsr_pkg::DATA_W
) (
    input  logic [WIDTH-1:0] operand_a,
    input  logic [WIDTH-1:0] operand_b,
    input  logic             dir_right,
    input  logic             mode_rotate,
    output logic [WIDTH-1:0] shift_out
);

    localparam int CNT_W = $clog2(WIDTH);
    localparam int HI_W  = WIDTH - CNT_W;

    bsr_pkg::move_ctrl_t ctrl_d;
    logic [WIDTH-1:0]    chain_d [CNT_W+1];

    always_comb begin
        ctrl_d.right  = dir_right;
        ctrl_d.rotate = mode_rotate;
        chain_d[0]    = operand_a;
    end

    // Stage k moves by 2**k when distance bit k is set.
    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        bsr_stage #(
            .WIDTH (WIDTH),
            .DIST  (1 << k)
        ) i_stage (
            .stage_in  (chain_d[k]),
            .take      (operand_b[k]),
            .ctrl      (ctrl_d),
            .stage_out (chain_d[k+1])
        );
    end

    bsr_range_guard #(
        .WIDTH (WIDTH),
        .HI_W  (HI_W)
    ) i_guard (
        .staged    (chain_d[CNT_W]),
        .dist_high (operand_b[WIDTH-1:CNT_W]),
        .rotate    (mode_rotate),
        .guarded   (shift_out)
    );

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] operand_a,
    input logic [WIDTH-1:0] operand_b,
    input logic             dir_right,
    input logic             mode_rotate,
    input logic [WIDTH-1:0] shift_out
);

    localparam int CNT_W = $clog2(WIDTH);

    logic [CNT_W-1:0] cnt;
    logic             hi_set;
    logic [WIDTH-1:0] ones;
    logic [WIDTH-1:0] low_mask;
    logic [WIDTH-1:0] high_mask;

    always_comb begin
        cnt       = operand_b[CNT_W-1:0];
        hi_set    = operand_b[WIDTH-1:CNT_W] != '0;
        ones      = '1;
        low_mask  = ~(ones << cnt);
        high_mask = ~(ones >> cnt);

        // R1: zero distance leaves the word as it was
        if (cnt == '0 && (mode_rotate || !hi_set))
            a_r1_zero_passthrough: assert (shift_out == operand_a);

        // R6: an over-range logical move clears the word
        if (!mode_rotate && hi_set)
            a_r6_overrange_zero: assert (shift_out == '0);

        // R8: a rotate keeps every one bit
        if (mode_rotate)
            a_r8_rotate_keeps_ones: assert ($countones(shift_out) == $countones(operand_a));

        // R2: left logical move leaves zeros at the bottom
        if (!mode_rotate && !dir_right && !hi_set)
            a_r2_left_low_zero: assert ((shift_out & low_mask) == '0);

        // R3: right logical move leaves zeros at the top
        if (!mode_rotate && dir_right && !hi_set)
            a_r3_right_high_zero: assert ((shift_out & high_mask) == '0);
    end

endmodule

bind barrel_shift_rotate bsr_checker #(.WIDTH(WIDTH)) i_bsr_checker (
    .operand_a   (operand_a),
    .operand_b   (operand_b),
    .dir_right   (dir_right),
    .mode_rotate (mode_rotate),
    .shift_out   (shift_out)
);

// File: tb/test_barrel_shift_rotate.sv
module test_barrel_shift_rotate;

    logic        clk = 1'b0;
    logic [15:0] operand_a = '0;
    logic [15:0] operand_b = '0;
    logic        dir_right = 1'b0;
    logic        mode_rotate = 1'b0;
    logic [15:0] shift_out;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    barrel_shift_rotate i_barrel_shift_rotate (
        .operand_a   (operand_a),
        .operand_b   (operand_b),
        .dir_right   (dir_right),
        .mode_rotate (mode_rotate),
        .shift_out   (shift_out)
    );

    // Reference built bit by bit from the requirement text.
    function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic right, input logic rot);
        logic [15:0] r;
        int n;
        n = int'(b[3:0]);
        r = '0;
        if (!rot && b[15:4] != 0) return '0;
        for (int i = 0; i < 16; i++) begin
            int src;
            src = right ? i + n : i - n;
            if (rot) r[i] = a[(src + 16) % 16];
            else if (src >= 0 && src < 16) r[i] = a[src];
        end
        return r;
    endfunction

    function automatic string tag_for(input logic [15:0] b, input logic right, input logic rot);
        if (b[15:4] != 0) return rot ? "R7" : "R6";
        if (b[3:0] == 0) return "R1";
        if (rot) return right ? "R5" : "R4";
        return right ? "R3" : "R2";
    endfunction

    task automatic run(input logic [15:0] a, input logic [15:0] b,
                       input logic right, input logic rot);
        logic [15:0] exp;
        @(posedge clk);
        operand_a   = a;
        operand_b   = b;
        dir_right   = right;
        mode_rotate = rot;
        exp = model(a, b, right, rot);
        @(negedge clk);
        n_checks++;
        if (shift_out !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h right=%b rot=%b actual=%h expected=%h",
                     tag_for(b, right, rot), a, b, right, rot, shift_out, exp);
        end
        if (rot) begin
            // R8: rotates keep the population count
            n_checks++;
            if ($countones(shift_out) != $countones(a)) begin
                n_fail++;
                $display("FAIL R8 a=%h b=%h actual=%0d expected=%0d",
                         a, b, $countones(shift_out), $countones(a));
            end
        end
    endtask

    initial begin
        logic [15:0] pats [4];
        pats[0] = 16'h8001;
        pats[1] = 16'hA5C3;
        pats[2] = 16'hFFFF;
        pats[3] = 16'h0001;
        void'($urandom(32'd4177));

        // Idle inputs: all zeros give a zero result (R1)
        @(negedge clk);
        n_checks++;
        if (shift_out !== 16'h0000) begin
            n_fail++;
            $display("FAIL R1 idle actual=%h expected=0000", shift_out);
        end

        // Full sweep: R1..R5 over every distance and mode
        for (int p = 0; p < 4; p++)
            for (int m = 0; m < 4; m++)
                for (int k = 0; k < 16; k++)
                    run(pats[p], 16'(k), m[0], m[1]);

        // Upper distance bits set: R6 for logical, R7 for rotate
        for (int m = 0; m < 4; m++)
            for (int k = 0; k < 16; k++) begin
                run(16'hC3A5, 16'h0010 | 16'(k), m[0], m[1]);
                run(16'h5A0F, 16'h8000 | 16'(k), m[0], m[1]);
            end

        // Random mix of all modes and distances
        for (int r = 0; r < 400; r++) begin
            logic [15:0] b;
            b = 16'($urandom);
            if ($urandom % 2 == 0) b[15:4] = '0;
            run(16'($urandom), b, 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule